// File: doc/BRIEF.md
# Compact Floating-Point Adder

This block adds two numbers held in a 12-bit floating-point word. The top bit is the sign. The next four bits hold the exponent offset by 8. The low seven bits hold the fraction, and a leading one is implied in front of it. The value of a normal word is ±1.fraction × 2^(exponent−8). Subtraction is done by flipping the sign of one operand before it enters the block.

Inside, a control section classifies both operands and decides which operand is the larger one. It also detects the special cases and hands its decisions to the datapath as a small bundle of strobes. The datapath routes the larger operand straight through and shifts only the smaller one into alignment. It keeps three low-order bits for rounding, then adds or subtracts the significands. The sum is normalized by a single right shift or by a left shift of its leading-zero count, then rounded to nearest even and packed. A parameter selects whether the result is registered once or left combinational.

Top module: `fp_add12`

## Requirements
- R1: With the word laid out as sign [11], offset-8 exponent [10:7] and fraction [6:0], two finite operands give the correctly rounded sum in the same layout; 0x59D plus 0x453 gives 0x5B7.
- R2: The result does not depend on operand order. When the signs differ, the result takes the sign of the operand with the larger magnitude.
- R3: When the significand sum reaches 2 or more, the result is shifted right by one place and the exponent rises by one; 0x400 plus 0x400 gives 0x480.
- R4: When subtraction leaves leading zeros, the result is shifted left until its leading bit is one, and the exponent drops by the same count; 0x401 plus 0xC00 gives 0x080.
- R5: Operands of equal magnitude and opposite sign give +0 (0x000), with both flags clear.
- R6: Rounding is to nearest, ties to even, from a guard bit, a round bit and a sticky bit. A rounding carry out of the significand renormalizes the result and raises the exponent by one.
- R7: A result exponent of 15 or more gives a correctly signed infinity (exponent 1111, fraction 0) and sets `ovf`.
- R8: A result exponent of 0 or less gives a correctly signed zero and sets `unf`.
- R9: An operand whose exponent field is 0 reads as zero. The other operand then passes through unchanged. Two zeros give a zero that is negative only when both are negative.
- R10: An operand whose exponent field is 1111 reads as infinity. It passes through as that signed infinity with both flags clear, and it takes priority over every other case.
- R11: With `OUT_REG` set, the result and flags change one clock after the inputs. A low `rstN` clears them to zero at once, whatever the inputs are.
- R12: `ovf` and `unf` are never set together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rstN | input | 1 | Asynchronous reset, active low |
| inA | input | 12 | First operand word |
| inB | input | 12 | Second operand word |
| result | output | 12 | Rounded sum word |
| ovf | output | 1 | Result saturated to infinity |
| unf | output | 1 | Result flushed to zero |

## Verification
The checks assume that no operand is a NaN and that no two infinities of opposite sign are added. Any word with an all-ones exponent is treated as infinity, and a mixed-sign pair of infinities has no defined meaning here. The check on cancellation also assumes that both operands are finite and nonzero. Every stimulus vector stays inside these limits: infinities are always paired with finite values, and the exponent 1111 appears only on a word with a zero fraction. The operands are held stable between clock edges, so each registered result can be matched against the inputs captured one cycle earlier.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  localparam int EXP_W  = 4;
  localparam int FRAC_W = 7;
  localparam int GRS_W  = 3;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = 1 + FRAC_W + GRS_W;
  localparam int EXT_W  = EXP_W + 2;
  localparam int LZ_W   = $clog2(SIG_W + 1);
  localparam logic [EXP_W-1:0] EXP_TOP = '1;

  typedef struct packed {
    logic swap;
    logic effSub;
    logic passInf;
    logic infSign;
    logic passA;
    logic passB;
    logic bothZero;
    logic zeroSign;
  } ctrl_t;
endpackage

// File: rtl/fpa_ctrl.sv
module fpa_ctrl
  import fpa_pkg::*;
(
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output ctrl_t             ctl
);
  logic [EXP_W-1:0] expA, expB;
  logic signA, signB, aZero, bZero, aInf, bInf;

  always_comb begin
    signA = opA[WORD_W-1];
    signB = opB[WORD_W-1];
    expA  = opA[WORD_W-2:FRAC_W];
    expB  = opB[WORD_W-2:FRAC_W];
    aZero = (expA == '0);
    bZero = (expB == '0);
    aInf  = (expA == EXP_TOP);
    bInf  = (expB == EXP_TOP);

    // larger magnitude goes on the unshifted path
    ctl.swap     = opB[WORD_W-2:0] > opA[WORD_W-2:0];
    ctl.effSub   = signA ^ signB;
    ctl.passInf  = aInf | bInf;
    ctl.infSign  = aInf ? signA : signB;
    ctl.bothZero = aZero & bZero;
    ctl.zeroSign = signA & signB;
    ctl.passA    = bZero & ~aZero;
    ctl.passB    = aZero & ~bZero;
  end
endmodule

// File: rtl/fpa_datapath.sv
module fpa_datapath
  import fpa_pkg::*;
(
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  ctrl_t             ctl,
  output logic [WORD_W-1:0] sumWord,
  output logic              ovfFlag,
  output logic              unfFlag
);
  logic [WORD_W-1:0]         bigW, smallW;
  logic [EXP_W-1:0]          bigExp, smallExp, expDiff;
  logic [SIG_W-1:0]          bigSig, smallSig, alignSig, normSig;
  logic [2*SIG_W-1:0]        alignExt;
  logic [SIG_W:0]            rawSum;
  logic [LZ_W-1:0]           lzCount;
  logic signed [EXT_W-1:0]   expNorm, expFinal;
  logic [FRAC_W+1:0]         rndSig;
  logic [FRAC_W-1:0]         fracOut;
  logic                      roundUp, sumZero, bigSign, carryOut;

  // swap, then align only the smaller operand
  always_comb begin
    bigW     = ctl.swap ? opB : opA;
    smallW   = ctl.swap ? opA : opB;
    bigSign  = bigW[WORD_W-1];
    bigExp   = bigW[WORD_W-2:FRAC_W];
    smallExp = smallW[WORD_W-2:FRAC_W];
    expDiff  = bigExp - smallExp;
    bigSig   = {1'b1, bigW[FRAC_W-1:0], {GRS_W{1'b0}}};
    smallSig = {1'b1, smallW[FRAC_W-1:0], {GRS_W{1'b0}}};
    alignExt = {smallSig, {SIG_W{1'b0}}} >> expDiff;
    alignSig = alignExt[2*SIG_W-1:SIG_W]
             | {{(SIG_W-1){1'b0}}, |alignExt[SIG_W-1:0]};
    rawSum   = ctl.effSub ? ({1'b0, bigSig} - {1'b0, alignSig})
                          : ({1'b0, bigSig} + {1'b0, alignSig});
    sumZero  = (rawSum == '0);
    carryOut = rawSum[SIG_W];
  end

  // leading-zero count below the carry position
  always_comb begin
    lzCount = LZ_W'(SIG_W);
    for (int i = 0; i < SIG_W; i++) begin
      if (rawSum[i]) lzCount = LZ_W'(SIG_W - 1 - i);
    end
  end

  // normalize and round
  always_comb begin
    if (carryOut) begin
      normSig = {rawSum[SIG_W:2], rawSum[1] | rawSum[0]};
      expNorm = $signed({2'b00, bigExp}) + EXT_W'(1);
    end else begin
      normSig = rawSum[SIG_W-1:0] << lzCount;
      expNorm = $signed({2'b00, bigExp})
              - $signed({{(EXT_W-LZ_W){1'b0}}, lzCount});
    end
    roundUp = normSig[GRS_W-1] & ((|normSig[GRS_W-2:0]) | normSig[GRS_W]);
    rndSig  = {1'b0, normSig[SIG_W-1:GRS_W]} + {{(FRAC_W+1){1'b0}}, roundUp};
    if (rndSig[FRAC_W+1]) begin
      expFinal = expNorm + EXT_W'(1);
      fracOut  = '0;
    end else begin
      expFinal = expNorm;
      fracOut  = rndSig[FRAC_W-1:0];
    end
  end

  // pack with special-case priority
  always_comb begin
    ovfFlag = 1'b0;
    unfFlag = 1'b0;
    if (ctl.passInf) begin
      sumWord = {ctl.infSign, EXP_TOP, {FRAC_W{1'b0}}};
    end else if (ctl.bothZero) begin
      sumWord = {ctl.zeroSign, {(WORD_W-1){1'b0}}};
    end else if (ctl.passA) begin
      sumWord = opA;
    end else if (ctl.passB) begin
      sumWord = opB;
    end else if (sumZero) begin
      sumWord = '0;
    end else if (expFinal >= $signed({2'b00, EXP_TOP})) begin
      sumWord = {bigSign, EXP_TOP, {FRAC_W{1'b0}}};
      ovfFlag = 1'b1;
    end else if (expFinal <= $signed(EXT_W'(0))) begin
      sumWord = {bigSign, {(WORD_W-1){1'b0}}};
      unfFlag = 1'b1;
    end else begin
      sumWord = {bigSign, expFinal[EXP_W-1:0], fracOut};
    end
  end

  always_comb begin
    // R2: control's swap leaves the larger magnitude on the unshifted path
    a_r2_big_first: assert (bigW[WORD_W-2:0] >= smallW[WORD_W-2:0])
      else $error("a_r2_big_first");
    // R4: normalizer output carries a leading one unless the sum is zero
    a_r4_lead_one: assert (sumZero || normSig[SIG_W-1])
      else $error("a_r4_lead_one");
  end
endmodule

// File: rtl/fp_add12.sv
module fp_add12
  import fpa_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] inA,
  input  logic [WORD_W-1:0] inB,
  output logic [WORD_W-1:0] result,
  output logic              ovf,
  output logic              unf
);
  ctrl_t             ctl;
  logic [WORD_W-1:0] sumWord;
  logic              ovfFlag, unfFlag;

  fpa_ctrl u_ctrl (.opA(inA), .opB(inB), .ctl(ctl));

  fpa_datapath u_dp (
    .opA(inA), .opB(inB), .ctl(ctl),
    .sumWord(sumWord), .ovfFlag(ovfFlag), .unfFlag(unfFlag)
  );

  logic [WORD_W-1:0] chkA, chkB;
  logic              primed;

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          result <= '0;
          ovf    <= 1'b0;
          unf    <= 1'b0;
          chkA   <= '0;
          chkB   <= '0;
        end else begin
          result <= sumWord;
          ovf    <= ovfFlag;
          unf    <= unfFlag;
          chkA   <= inA;
          chkB   <= inB;
        end
      end
    end else begin : g_comb
      assign result = sumWord;
      assign ovf    = ovfFlag;
      assign unf    = unfFlag;
      assign chkA   = inA;
      assign chkB   = inB;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  logic cancelObs, infAObs;
  always_comb begin
    cancelObs = (chkA[WORD_W-2:0] == chkB[WORD_W-2:0])
              && (chkA[WORD_W-1] != chkB[WORD_W-1])
              && (chkA[WORD_W-2:FRAC_W] != '0)
              && (chkA[WORD_W-2:FRAC_W] != EXP_TOP);
    infAObs   = (chkA[WORD_W-2:FRAC_W] == EXP_TOP)
              && (chkB[WORD_W-2:FRAC_W] != EXP_TOP);
  end

  a_r12_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(ovf && unf));
  a_r7_ovf_is_inf: assert property (@(posedge clk) disable iff (!rstN)
    ovf |-> result[WORD_W-2:0] == {EXP_TOP, {FRAC_W{1'b0}}});
  a_r8_unf_is_zero: assert property (@(posedge clk) disable iff (!rstN)
    unf |-> result[WORD_W-2:0] == {(WORD_W-1){1'b0}});
  a_r5_cancel_pos_zero: assert property (@(posedge clk) disable iff (!rstN)
    (primed && cancelObs) |-> (result == '0 && !ovf && !unf));
  a_r10_inf_passes: assert property (@(posedge clk) disable iff (!rstN)
    (primed && infAObs) |->
      (result == {chkA[WORD_W-1], EXP_TOP, {FRAC_W{1'b0}}} && !ovf && !unf));
endmodule

// File: tb/fp_add12_tb_top.sv
module fp_add12_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN;
  logic [11:0] inA, inB, result;
  logic        ovf, unf;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  fp_add12 dut_i (
    .clk(clk), .rstN(rstN), .inA(inA), .inB(inB),
    .result(result), .ovf(ovf), .unf(unf)
  );

  // {a, b, expected result, ovf, unf}
  localparam int NV = 22;
  localparam logic [37:0] VECS [NV] = '{
    {12'h59D, 12'h453, 12'h5B7, 2'b00},  // R1 aligned add, no shift
    {12'h453, 12'h59D, 12'h5B7, 2'b00},  // R2 swapped order
    {12'h400, 12'h400, 12'h480, 2'b00},  // R3 carry, right shift
    {12'h440, 12'hC00, 12'h380, 2'b00},  // R4 one-place left shift
    {12'h401, 12'hC00, 12'h080, 2'b00},  // R4 seven-place left shift
    {12'h400, 12'hC80, 12'hC00, 2'b00},  // R2 sign of larger (second)
    {12'hC80, 12'h400, 12'hC00, 2'b00},  // R2 sign of larger (first)
    {12'h400, 12'hC00, 12'h000, 2'b00},  // R5 exact cancellation
    {12'h480, 12'h080, 12'h480, 2'b00},  // R6 tie, even stays
    {12'h481, 12'h080, 12'h482, 2'b00},  // R6 tie, odd rounds up
    {12'h480, 12'h081, 12'h481, 2'b00},  // R6 sticky breaks tie
    {12'h4FF, 12'h080, 12'h500, 2'b00},  // R6 round carry renormalizes
    {12'h480, 12'h881, 12'h47F, 2'b00},  // R6 subtract with sticky
    {12'h77F, 12'h77F, 12'h780, 2'b10},  // R7 positive overflow
    {12'hF7F, 12'hF7F, 12'hF80, 2'b10},  // R7 negative overflow
    {12'h0C0, 12'h880, 12'h000, 2'b01},  // R8 positive underflow
    {12'h8C0, 12'h080, 12'h800, 2'b01},  // R8 negative underflow
    {12'h000, 12'h453, 12'h453, 2'b00},  // R9 zero first
    {12'h453, 12'h000, 12'h453, 2'b00},  // R9 zero second
    {12'h800, 12'h800, 12'h800, 2'b00},  // R9 two negative zeros
    {12'h780, 12'h400, 12'h780, 2'b00},  // R10 infinity first
    {12'h400, 12'hF80, 12'hF80, 2'b00}   // R10 infinity second
  };
  localparam int REQS [NV] = '{1, 2, 3, 4, 4, 2, 2, 5, 6, 6, 6,
                               6, 6, 7, 7, 8, 8, 9, 9, 9, 10, 10};

  task automatic check(input int req, input logic [13:0] act,
                       input logic [13:0] expv, input string what);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    rstN = 1'b0;
    inA  = 12'h77F;
    inB  = 12'h77F;
    repeat (3) @(negedge clk);
    // R11: reset holds outputs at zero despite overflowing inputs
    check(11, {result, ovf, unf}, 14'h0000, "reset state");
    rstN = 1'b1;
    inA  = 12'h000;
    inB  = 12'h000;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      inA = VECS[k][37:26];
      inB = VECS[k][25:14];
      @(negedge clk);
      check(REQS[k], {result, ovf, unf}, VECS[k][13:0], "vector");
      // R12: flags never both set
      check(12, {13'b0, ovf & unf}, 14'h0000, "flag exclusivity");
    end

    // R11: one-cycle latency
    inA = 12'h400;
    inB = 12'h400;
    @(negedge clk);
    check(3, {result, ovf, unf}, {12'h480, 2'b00}, "carry before latency test");
    inA = 12'h440;
    inB = 12'hC00;
    #2;
    check(11, {result, ovf, unf}, {12'h480, 2'b00}, "output holds before edge");
    @(negedge clk);
    check(11, {result, ovf, unf}, {12'h380, 2'b00}, "output after edge");

    // R11: asynchronous reset mid-run
    inA = 12'h77F;
    inB = 12'h77F;
    @(negedge clk);
    check(7, {result, ovf, unf}, {12'h780, 2'b10}, "overflow before reset");
    rstN = 1'b0;
    #2;
    check(11, {result, ovf, unf}, 14'h0000, "async reset clears");
    @(negedge clk);
    rstN = 1'b1;
    finishRun();
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end
endmodule